// File: doc/BRIEF.md
# Processor Exception Dispatch Unit

This block sits beside a processor core and turns an accepted exception request into the special-register updates that come with it. The core presents a request with a cause code, the faulting PC and, optionally, a faulting virtual address, along with its current status word. In one clock edge the block picks a vector, commits the saved-PC, cause, faulting-address and debug registers it owns, and returns a new status word. A one-cycle strobe marks that edge. The core copies `statusOut` into its status register and redirects fetch to the vector that `vecId` names.

Debug requests follow a separate path. They save state into the registers of a debug interrupt level fixed at build time, and they are accepted only when the core's current interrupt level is below that level. The double-exception saved-PC register is optional. It is chosen by parameter, and when it is left out, double exceptions reuse the level-1 saved-PC register.

Status word layout: bits [3:0] hold the interrupt level, bit 4 is the exception-mode flag and bit 5 is the user-mode flag. All other bits are passed through. Vector codes on `vecId`: 0 kernel, 1 user, 2 double, 3 debug.

Top module: `exc_dispatch`

## Requirements
- R1: While `rstN` is low, every register output and `takeExc` read zero, and requests are ignored.
- R2: An accepted general request whose status has bit 4 clear writes `reqPc` into `epc1Out`. It reports vector 1 (user) when status bit 5 is set and vector 0 (kernel) otherwise.
- R3: An accepted general request whose status has bit 4 set is a double exception and reports vector 2. With the double-exception register built in, `reqPc` goes to `depcOut` and `epc1Out` keeps its value.
- R4: With the double-exception register left out, a double exception writes `reqPc` into `epc1Out`, and `depcOut` stays zero.
- R5: Every accepted general request writes `genCause` into `causeOut`. It returns `statusOut` equal to `statusIn` with bit 4 set and every other bit unchanged.
- R6: `faultVaddr` is written into `vaddrOut` only by an accepted general request that has `vaddrValid` high. Any other request leaves `vaddrOut` unchanged.
- R7: An accepted debug request writes `dbgCause` into `dbgCauseOut`, `reqPc` into `dbgEpcOut` and `statusIn` into `dbgEpsOut`. It reports vector 3 and returns `statusOut` with bits [3:0] set to the debug level (6 by default), bit 4 set and the other bits unchanged.
- R8: A debug request is accepted only when `statusIn[3:0]` is below the debug level. A refused debug request changes no output and produces no strobe, unless a general request is present in the same cycle.
- R9: When an accepted debug request and a general request arrive in the same cycle, the debug request wins. The general request then changes none of `epc1Out`, `depcOut`, `causeOut` or `vaddrOut`. A general request that arrives with a refused debug request is dispatched normally.
- R10: `takeExc` is high for exactly the cycle after each edge that samples an accepted request. All register outputs, `vecId` and `statusOut` take their new values on that same edge. With no accepted request, the register outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| genReq | input | 1 | General exception request |
| dbgReq | input | 1 | Debug exception request |
| reqPc | input | PC_W | Faulting PC of the request |
| genCause | input | CAUSE_W | Cause code of a general request |
| vaddrValid | input | 1 | Request carries a faulting virtual address |
| faultVaddr | input | PC_W | Faulting virtual address |
| dbgCause | input | DCAUSE_W | Cause code of a debug request |
| statusIn | input | 8 | Current processor status word |
| takeExc | output | 1 | One-cycle strobe: exception taken |
| vecId | output | 2 | Chosen vector (0 kernel, 1 user, 2 double, 3 debug) |
| statusOut | output | 8 | Status word to load on `takeExc` |
| epc1Out | output | PC_W | Level-1 saved PC |
| depcOut | output | PC_W | Double-exception saved PC |
| causeOut | output | CAUSE_W | Exception cause register |
| vaddrOut | output | PC_W | Faulting virtual address register |
| dbgCauseOut | output | DCAUSE_W | Debug cause register |
| dbgEpcOut | output | PC_W | Saved PC of the debug level |
| dbgEpsOut | output | 8 | Saved status of the debug level |

## Verification
A wrong accept decision or a wrong routing decision shows at the ports one edge after the request. It appears as a missing or extra strobe, a wrong vector code, or a register that moved when it should have held. The bench therefore compares every register output after every request, including the ones that should not change. It sweeps the full interrupt-level range, both mode flags and all four request combinations, with and without a faulting address, on two builds: one with the double-exception register and one without. A corrupted held value persists, so it is caught at the next comparison and never more than two cycles later.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;
  // status word layout shared with the core
  localparam int PS_W     = 8;
  localparam int LVL_W    = 4;
  localparam int EXCM_BIT = 4;
  localparam int UM_BIT   = 5;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeGen;
    logic takeDbg;
    logic saveEpc1;
    logic saveDepc;
    vec_e vec;
  } exc_ctl_t;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_dispatch_pkg::*;
#(
  parameter int DBG_LEVEL = 6,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic            genReq,
  input  logic            dbgReq,
  input  logic [PS_W-1:0] statusIn,
  output exc_ctl_t        ctl
);
  localparam logic [LVL_W-1:0] DBG_LVL = LVL_W'(DBG_LEVEL);

  logic dbgOk;
  logic isDouble;

  always_comb begin
    dbgOk    = dbgReq && (statusIn[LVL_W-1:0] < DBG_LVL);
    isDouble = statusIn[EXCM_BIT];
    ctl.takeDbg  = dbgOk;
    ctl.takeGen  = genReq && !dbgOk;
    ctl.saveDepc = ctl.takeGen && isDouble && HAS_DEPC;
    ctl.saveEpc1 = ctl.takeGen && !(isDouble && HAS_DEPC);
    if (dbgOk)                  ctl.vec = VEC_DEBUG;
    else if (isDouble)          ctl.vec = VEC_DOUBLE;
    else if (statusIn[UM_BIT])  ctl.vec = VEC_USER;
    else                        ctl.vec = VEC_KERNEL;
  end
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_dispatch_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int CAUSE_W   = 6,
  parameter int DCAUSE_W  = 4,
  parameter int DBG_LEVEL = 6,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  exc_ctl_t            ctl,
  input  logic [PC_W-1:0]     reqPc,
  input  logic [CAUSE_W-1:0]  genCause,
  input  logic                vaddrValid,
  input  logic [PC_W-1:0]     faultVaddr,
  input  logic [DCAUSE_W-1:0] dbgCause,
  input  logic [PS_W-1:0]     statusIn,
  output logic                takeExc,
  output vec_e                vecId,
  output logic [PS_W-1:0]     statusOut,
  output logic [PC_W-1:0]     epc1Out,
  output logic [PC_W-1:0]     depcOut,
  output logic [CAUSE_W-1:0]  causeOut,
  output logic [PC_W-1:0]     vaddrOut,
  output logic [DCAUSE_W-1:0] dbgCauseOut,
  output logic [PC_W-1:0]     dbgEpcOut,
  output logic [PS_W-1:0]     dbgEpsOut
);
  localparam logic [LVL_W-1:0] DBG_LVL = LVL_W'(DBG_LEVEL);

  logic [PS_W-1:0] statusNext;
  logic            anyTake;

  always_comb begin
    anyTake    = ctl.takeGen || ctl.takeDbg;
    statusNext = statusIn;
    statusNext[EXCM_BIT] = 1'b1;
    if (ctl.takeDbg) statusNext[LVL_W-1:0] = DBG_LVL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeExc     <= 1'b0;
      vecId       <= VEC_KERNEL;
      statusOut   <= '0;
      epc1Out     <= '0;
      causeOut    <= '0;
      vaddrOut    <= '0;
      dbgCauseOut <= '0;
      dbgEpcOut   <= '0;
      dbgEpsOut   <= '0;
    end else begin
      takeExc <= anyTake;
      if (anyTake) begin
        vecId     <= ctl.vec;
        statusOut <= statusNext;
      end
      if (ctl.saveEpc1) epc1Out <= reqPc;
      if (ctl.takeGen) begin
        causeOut <= genCause;
        if (vaddrValid) vaddrOut <= faultVaddr;
      end
      if (ctl.takeDbg) begin
        dbgCauseOut <= dbgCause;
        dbgEpcOut   <= reqPc;
        dbgEpsOut   <= statusIn;
      end
    end
  end

  generate
    if (HAS_DEPC) begin : g_depc
      logic [PC_W-1:0] depcQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             depcQ <= '0;
        else if (ctl.saveDepc) depcQ <= reqPc;
      end
      assign depcOut = depcQ;
    end else begin : g_nodepc
      assign depcOut = '0;
    end
  endgenerate

  // R2: user vector only from a non-double request in user mode
  a_r2_user_vec: assert property (@(posedge clk) disable iff (!rstN)
    takeExc && vecId == VEC_USER |-> $past(statusIn[UM_BIT]) && !$past(statusIn[EXCM_BIT]));
  // R3: double vector only when exception mode was already set
  a_r3_double_vec: assert property (@(posedge clk) disable iff (!rstN)
    takeExc && vecId == VEC_DOUBLE |-> $past(statusIn[EXCM_BIT]));
  // R5: every taken exception leaves exception mode set
  a_r5_excm_set: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |-> statusOut[EXCM_BIT]);
  // R7: debug entry raises the level to the debug level
  a_r7_dbg_level: assert property (@(posedge clk) disable iff (!rstN)
    takeExc && vecId == VEC_DEBUG |-> statusOut[LVL_W-1:0] == DBG_LVL);
  // R8: debug accepted only from a lower level
  a_r8_dbg_gate: assert property (@(posedge clk) disable iff (!rstN)
    takeExc && vecId == VEC_DEBUG |-> $past(statusIn[LVL_W-1:0]) < DBG_LVL);
  // R10: registers hold without a taken exception
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !takeExc |-> $stable(epc1Out) && $stable(causeOut) && $stable(vaddrOut) && $stable(dbgEpcOut));
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_dispatch_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int CAUSE_W   = 6,
  parameter int DCAUSE_W  = 4,
  parameter int DBG_LEVEL = 6,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                genReq,
  input  logic                dbgReq,
  input  logic [PC_W-1:0]     reqPc,
  input  logic [CAUSE_W-1:0]  genCause,
  input  logic                vaddrValid,
  input  logic [PC_W-1:0]     faultVaddr,
  input  logic [DCAUSE_W-1:0] dbgCause,
  input  logic [7:0]          statusIn,
  output logic                takeExc,
  output logic [1:0]          vecId,
  output logic [7:0]          statusOut,
  output logic [PC_W-1:0]     epc1Out,
  output logic [PC_W-1:0]     depcOut,
  output logic [CAUSE_W-1:0]  causeOut,
  output logic [PC_W-1:0]     vaddrOut,
  output logic [DCAUSE_W-1:0] dbgCauseOut,
  output logic [PC_W-1:0]     dbgEpcOut,
  output logic [7:0]          dbgEpsOut
);
  exc_ctl_t ctl;
  vec_e     vecQ;

  exc_ctrl #(.DBG_LEVEL(DBG_LEVEL), .HAS_DEPC(HAS_DEPC)) u_ctrl (
    .genReq(genReq), .dbgReq(dbgReq), .statusIn(statusIn), .ctl(ctl)
  );

  exc_datapath #(
    .PC_W(PC_W), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W),
    .DBG_LEVEL(DBG_LEVEL), .HAS_DEPC(HAS_DEPC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqPc(reqPc), .genCause(genCause),
    .vaddrValid(vaddrValid), .faultVaddr(faultVaddr), .dbgCause(dbgCause),
    .statusIn(statusIn), .takeExc(takeExc), .vecId(vecQ), .statusOut(statusOut),
    .epc1Out(epc1Out), .depcOut(depcOut), .causeOut(causeOut), .vaddrOut(vaddrOut),
    .dbgCauseOut(dbgCauseOut), .dbgEpcOut(dbgEpcOut), .dbgEpsOut(dbgEpsOut)
  );

  assign vecId = vecQ;
endmodule

// File: tb/tb_exc_dispatch.sv
module tb_exc_dispatch;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic genReq = 1'b0, dbgReq = 1'b0, vaddrValid = 1'b0;
  logic [31:0] reqPc = '0, faultVaddr = '0;
  logic [5:0]  genCause = '0;
  logic [3:0]  dbgCause = '0;
  logic [7:0]  statusIn = '0;

  logic        takeA, takeB;
  logic [1:0]  vecA, vecB;
  logic [7:0]  stA, stB, epsA, epsB;
  logic [31:0] epc1A, epc1B, depcA, depcB, vaA, vaB, dEpcA, dEpcB;
  logic [5:0]  causeA, causeB;
  logic [3:0]  dCauseA, dCauseB;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  exc_dispatch dut (
    .clk(clk), .rstN(rstN), .genReq(genReq), .dbgReq(dbgReq), .reqPc(reqPc),
    .genCause(genCause), .vaddrValid(vaddrValid), .faultVaddr(faultVaddr),
    .dbgCause(dbgCause), .statusIn(statusIn), .takeExc(takeA), .vecId(vecA),
    .statusOut(stA), .epc1Out(epc1A), .depcOut(depcA), .causeOut(causeA),
    .vaddrOut(vaA), .dbgCauseOut(dCauseA), .dbgEpcOut(dEpcA), .dbgEpsOut(epsA)
  );

  exc_dispatch #(.HAS_DEPC(1'b0)) dutNoDepc (
    .clk(clk), .rstN(rstN), .genReq(genReq), .dbgReq(dbgReq), .reqPc(reqPc),
    .genCause(genCause), .vaddrValid(vaddrValid), .faultVaddr(faultVaddr),
    .dbgCause(dbgCause), .statusIn(statusIn), .takeExc(takeB), .vecId(vecB),
    .statusOut(stB), .epc1Out(epc1B), .depcOut(depcB), .causeOut(causeB),
    .vaddrOut(vaB), .dbgCauseOut(dCauseB), .dbgEpcOut(dEpcB), .dbgEpsOut(epsB)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench model
  logic [31:0] mEpc1A = '0, mEpc1B = '0, mDepc = '0, mVa = '0, mDEpc = '0;
  logic [5:0]  mCause = '0;
  logic [3:0]  mDCause = '0;
  logic [7:0]  mEps = '0, mSt = '0;
  logic [1:0]  mVecA, mVecB;

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: requests during reset are ignored
    @(negedge clk);
    genReq = 1'b1; dbgReq = 1'b1; vaddrValid = 1'b1;
    reqPc = 32'hdead_beef; faultVaddr = 32'h1234_5678; genCause = 6'h3f; dbgCause = 4'hf;
    repeat (3) @(negedge clk);
    check("R1 take", {31'b0, takeA}, 32'd0);
    check("R1 epc1", epc1A, 32'd0);
    check("R1 depc", depcA, 32'd0);
    check("R1 cause", {26'b0, causeA}, 32'd0);
    check("R1 vaddr", vaA, 32'd0);
    check("R1 dbgEpc", dEpcA, 32'd0);
    check("R1 status", {24'b0, stA}, 32'd0);
    genReq = 1'b0; dbgReq = 1'b0; vaddrValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {31'b0, takeA}, 32'd0);

    for (int idx = 0; idx < 512; idx++) begin
      automatic logic [3:0] lvl = idx[3:0];
      automatic logic excm = idx[4];
      automatic logic um = idx[5];
      automatic logic g = idx[6];
      automatic logic d = idx[7];
      automatic logic vv = idx[8];
      automatic logic [7:0] st = {idx[0] ^ idx[6], 1'b0, um, excm, lvl};
      automatic logic dbgOk = d && (lvl < 4'd6);
      automatic logic tk = dbgOk || g;
      reqPc = 32'h4000_0000 + idx * 4;
      faultVaddr = 32'h8000_0000 ^ (idx * 32'h0001_0101);
      genCause = 6'(idx * 5 + 1);
      dbgCause = 4'(idx * 3 + 2);
      statusIn = st; genReq = g; dbgReq = d; vaddrValid = vv;
      if (dbgOk) begin
        mDCause = dbgCause; mDEpc = reqPc; mEps = st;
        mSt = {st[7:5], 1'b1, 4'd6};
        mVecA = 2'd3; mVecB = 2'd3;
      end else if (g) begin
        mCause = genCause;
        if (vv) mVa = faultVaddr;
        mSt = st | 8'h10;
        if (excm) begin
          mDepc = reqPc; mEpc1B = reqPc; mVecA = 2'd2; mVecB = 2'd2;
        end else begin
          mEpc1A = reqPc; mEpc1B = reqPc;
          mVecA = um ? 2'd1 : 2'd0; mVecB = mVecA;
        end
      end
      @(negedge clk);
      genReq = 1'b0; dbgReq = 1'b0; vaddrValid = 1'b0;
      check("R10 strobe", {31'b0, takeA}, {31'b0, tk});
      check("R8 strobe no-depc build", {31'b0, takeB}, {31'b0, tk});
      if (tk) begin
        check(dbgOk ? "R7 vector" : "R2 R3 vector", {30'b0, vecA}, {30'b0, mVecA});
        check("R4 vector", {30'b0, vecB}, {30'b0, mVecB});
        check(dbgOk ? "R7 status" : "R5 status", {24'b0, stA}, {24'b0, mSt});
      end
      check("R2 R9 epc1", epc1A, mEpc1A);
      check("R3 depc", depcA, mDepc);
      check("R4 epc1 no-depc", epc1B, mEpc1B);
      check("R4 depc absent", depcB, 32'd0);
      check("R5 R9 cause", {26'b0, causeA}, {26'b0, mCause});
      check("R6 vaddr", vaA, mVa);
      check("R7 dbgCause", {28'b0, dCauseA}, {28'b0, mDCause});
      check("R7 R8 dbgEpc", dEpcA, mDEpc);
      check("R7 dbgEps", {24'b0, epsA}, {24'b0, mEps});
      @(negedge clk);
      check("R10 strobe one cycle", {31'b0, takeA}, 32'd0);
      check("R10 hold epc1", epc1A, mEpc1A);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule